// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit-wide first-in first-out buffer. Its write side and read side run on separate, unrelated clocks. Writes and reads are requested through active-low enables. The buffer holds 2^ADDR_W words. The default is 256 words, and depths up to 4K words are supported.

Five active-low status outputs report the fill level:
- empty, in the read domain;
- full, in the write domain;
- more-than-half-full, in the write domain;
- almost-empty;
- almost-full.

The last two compare the fill level against two threshold values. Software sets the thresholds through the ordinary data buses. While the active-low load strobe is held low, enabled writes go into the threshold store instead of the buffer, and enabled reads return the thresholds. A mode input selects the timing of the almost flags. When it is high, they are computed combinationally from both live pointers. When it is low, each is registered in the clock domain it belongs to.

A retransmit input restarts reading from the first word written after reset. It lets a frame that fits in the buffer be replayed.

Top module: `pflag_async_fifo`

## Requirements
- R1: Words are returned on `dataOut` in the order they were accepted. A word is accepted on a rising `wrClk` edge with `wrEnN` low, `loadN` high and the buffer not full. A word is delivered one `rdClk` edge after a read with `rdEnN` low, `loadN` high and the buffer not empty.
- R2: `fullN` is low exactly when the write side sees 2^ADDR_W stored words. Writes attempted in that state are discarded.
- R3: `emptyN` is low exactly when the read side sees zero stored words. A read attempted in that state leaves `dataOut` unchanged.
- R4: `halfFullN` is low when the stored word count is greater than 2^ADDR_W / 2.
- R5: `almostEmptyN` is low when the stored word count is at or below the empty threshold.
- R6: `almostFullN` is low when the free space (2^ADDR_W minus the count) is at or below the full threshold.
- R7: With `asyncMode` high, the almost flags follow a write or read within the same clock period, without waiting for an edge of the other clock. With `asyncMode` low, `almostEmptyN` is registered on `rdClk` and `almostFullN` on `wrClk`. Crossing-domain pointer changes reach them only after a two-flop synchroniser.
- R8: Each enabled write with `loadN` low stores `dataIn[ADDR_W:0]` into a threshold. Successive load writes alternate between the thresholds, empty threshold first. Load writes never change the buffer contents or the word count.
- R9: Each enabled read with `loadN` low returns a threshold on `dataOut`, zero-extended. Successive load reads alternate, empty threshold first. Load reads leave the buffer untouched.
- R10: `retransN` sampled low on a `rdClk` edge moves the read position back to the first location. Retransmit takes priority over a read in the same cycle. It is valid while fewer than 2^ADDR_W words have been written since reset.
- R11: `rstN` low clears both pointers, sets `dataOut` to zero, sets both thresholds to 7 and restarts both threshold alternations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| asyncMode | input | 1 | 1: combinational almost flags; 0: registered almost flags |
| wrEnN | input | 1 | Active-low write enable |
| rdEnN | input | 1 | Active-low read enable |
| loadN | input | 1 | Active-low threshold access strobe |
| retransN | input | 1 | Active-low retransmit request, read domain |
| dataIn | input | WIDTH | Write data or threshold value |
| dataOut | output | WIDTH | Read data or threshold readback |
| emptyN | output | 1 | Active-low empty flag |
| fullN | output | 1 | Active-low full flag |
| halfFullN | output | 1 | Active-low more-than-half-full flag |
| almostEmptyN | output | 1 | Active-low almost-empty flag |
| almostFullN | output | 1 | Active-low almost-full flag |

## Verification
The bench uses a 16-word buffer and sweeps every fill level from 0 to 16 in both flag modes. At each level it checks all five flags against values computed from the count and the thresholds:
- A design whose comparisons are off by one would flip a flag at the boundary levels 3, 8, 14 and 16.
- Overfilling by two words, then draining, catches a write that slips past the full state, because it corrupts the read order.
- Reading one word past empty catches a read that advances when it should not.

One test samples `almostEmptyN` one nanosecond after a write, before any read-clock edge. It then expects opposite results in the two modes, so a swapped or merged mode path is caught. The threshold tests check the alternation order, that bits above the threshold width are truncated, and that the buffer stays empty afterwards. The retransmit test replays a five-word frame and checks it word for word.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Strobes from the control block to the datapath; each field is
  // produced in the clock domain of the logic that consumes it.
  typedef struct packed {
    logic memWr;   // store dataIn in the buffer (write domain)
    logic offWr;   // store dataIn in a threshold (write domain)
    logic memRd;   // deliver next buffer word (read domain)
    logic offRd;   // deliver a threshold (read domain)
  } dcfStrobe_t;

endpackage

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the XOR of all gray bits at or above it.
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc       = acc ^ stage2[i];
      binOut[i] = acc;
    end
  end

endmodule

// File: rtl/dcf_ctrl.sv
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int PW    = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              asyncMode,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic              loadN,
  input  logic              retransN,
  input  logic [PW-1:0]     emptyOff,
  input  logic [PW-1:0]     fullOff,
  output dcfStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyN,
  output logic              fullN,
  output logic              halfFullN,
  output logic              almostEmptyN,
  output logic              almostFullN
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  logic [PW-1:0] wrPtr, wrGray, wrPtrNext;
  logic [PW-1:0] rdPtr, rdGray, rdPtrNext;
  logic [PW-1:0] wrSeesRd, rdSeesWr;
  logic [PW-1:0] wrCount, rdCount, liveCount;
  logic          isFull, isEmpty;
  logic          aeAsync, afAsync;
  logic          aeReg, afReg;

  // Crossing pointers travel as gray code
  dcf_ptr_sync #(.W(PW)) rdToWr_i (
    .clk(wrClk), .rstN(rstN), .grayIn(rdGray), .binOut(wrSeesRd)
  );
  dcf_ptr_sync #(.W(PW)) wrToRd_i (
    .clk(rdClk), .rstN(rstN), .grayIn(wrGray), .binOut(rdSeesWr)
  );

  assign wrCount   = wrPtr - wrSeesRd;
  assign rdCount   = rdSeesWr - rdPtr;
  assign isFull    = (wrCount == DEPTH_P);
  assign isEmpty   = (rdCount == '0);
  assign wrPtrNext = wrPtr + PW'(1);
  assign rdPtrNext = rdPtr + PW'(1);

  always_comb begin
    strobe.memWr = !wrEnN && loadN && !isFull;
    strobe.offWr = !wrEnN && !loadN;
    strobe.memRd = !rdEnN && loadN && !isEmpty && retransN;
    strobe.offRd = !rdEnN && !loadN;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else if (strobe.memWr) begin
      wrPtr  <= wrPtrNext;
      wrGray <= wrPtrNext ^ (wrPtrNext >> 1);
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      rdGray <= '0;
    end else if (!retransN) begin
      rdPtr  <= '0;
      rdGray <= '0;
    end else if (strobe.memRd) begin
      rdPtr  <= rdPtrNext;
      rdGray <= rdPtrNext ^ (rdPtrNext >> 1);
    end
  end

  // Combinational almost flags from both live pointers
  assign liveCount = wrPtr - rdPtr;
  assign aeAsync   = (liveCount <= emptyOff);
  assign afAsync   = ((DEPTH_P - liveCount) <= fullOff);

  // Registered almost flags, each in its own domain
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) aeReg <= 1'b1;
    else       aeReg <= (rdCount <= emptyOff);
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) afReg <= 1'b0;
    else       afReg <= ((DEPTH_P - wrCount) <= fullOff);
  end

  assign wrAddr       = wrPtr[ADDR_W-1:0];
  assign rdAddr       = rdPtr[ADDR_W-1:0];
  assign emptyN       = !isEmpty;
  assign fullN        = !isFull;
  assign halfFullN    = !(wrCount > HALF_P);
  assign almostEmptyN = asyncMode ? !aeAsync : !aeReg;
  assign almostFullN  = asyncMode ? !afAsync : !afReg;

endmodule

// File: rtl/dcf_datapath.sv
module dcf_datapath
  import dcf_pkg::*;
#(
  parameter int WIDTH       = 18,
  parameter int ADDR_W      = 8,
  parameter int DEFAULT_OFF = 7,
  localparam int PW         = ADDR_W + 1,
  localparam int DEPTH      = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  dcfStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WIDTH-1:0]  dataIn,
  output logic [WIDTH-1:0]  dataOut,
  output logic [PW-1:0]     emptyOff,
  output logic [PW-1:0]     fullOff
);

  localparam logic [PW-1:0] DEF_P = PW'(DEFAULT_OFF);

  logic [WIDTH-1:0] mem [DEPTH];
  logic             wrSel;
  logic             rdSel;

  always_ff @(posedge wrClk) begin
    if (strobe.memWr) mem[wrAddr] <= dataIn;
  end

  // Threshold store, written alternately: empty first, then full
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      emptyOff <= DEF_P;
      fullOff  <= DEF_P;
      wrSel    <= 1'b0;
    end else if (strobe.offWr) begin
      if (wrSel) fullOff  <= dataIn[PW-1:0];
      else       emptyOff <= dataIn[PW-1:0];
      wrSel <= !wrSel;
    end
  end

  // Output register: threshold readback or buffer word
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      rdSel   <= 1'b0;
    end else if (strobe.offRd) begin
      dataOut <= WIDTH'(rdSel ? fullOff : emptyOff);
      rdSel   <= !rdSel;
    end else if (strobe.memRd) begin
      dataOut <= mem[rdAddr];
    end
  end

endmodule

// File: rtl/pflag_async_fifo.sv
module pflag_async_fifo
  import dcf_pkg::*;
#(
  parameter int WIDTH          = 18,
  parameter int ADDR_W         = 8,
  parameter int DEFAULT_OFFSET = 7
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             asyncMode,
  input  logic             wrEnN,
  input  logic             rdEnN,
  input  logic             loadN,
  input  logic             retransN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             emptyN,
  output logic             fullN,
  output logic             halfFullN,
  output logic             almostEmptyN,
  output logic             almostFullN
);

  localparam int PW = ADDR_W + 1;

  dcfStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [PW-1:0]     emptyOff, fullOff;

  dcf_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .asyncMode(asyncMode),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .loadN(loadN), .retransN(retransN),
    .emptyOff(emptyOff), .fullOff(fullOff), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .emptyN(emptyN), .fullN(fullN),
    .halfFullN(halfFullN), .almostEmptyN(almostEmptyN),
    .almostFullN(almostFullN)
  );

  dcf_datapath #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DEFAULT_OFF(DEFAULT_OFFSET)
  ) datapath_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .dataIn(dataIn), .dataOut(dataOut),
    .emptyOff(emptyOff), .fullOff(fullOff)
  );

endmodule

// File: rtl/pflag_async_fifo_chk.sv
module pflag_async_fifo_chk #(
  parameter int WIDTH  = 18,
  parameter int ADDR_W = 8
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rstN,
  input logic             asyncMode,
  input logic             rdEnN,
  input logic             loadN,
  input logic             retransN,
  input logic [WIDTH-1:0] dataOut,
  input logic             emptyN,
  input logic             fullN,
  input logic             almostEmptyN,
  input logic             almostFullN
);

  assert_empty_read_hold_R3: assert property (
    @(posedge rdClk) disable iff (!rstN)
    (!emptyN && !rdEnN && loadN && retransN) |=> $stable(dataOut));

  assert_offset_readback_narrow_R9: assert property (
    @(posedge rdClk) disable iff (!rstN)
    (!loadN && !rdEnN) |=> (dataOut[WIDTH-1:ADDR_W+1] == '0));

  assert_full_implies_almost_full_R6: assert property (
    @(posedge wrClk) disable iff (!rstN)
    (!fullN && !asyncMode) |=> !almostFullN);

  assert_empty_implies_almost_empty_R5: assert property (
    @(posedge rdClk) disable iff (!rstN)
    (!emptyN && !asyncMode) |=> !almostEmptyN);

  always @(posedge rdClk) begin
    if (!rstN) assert_reset_output_zero_R11: assert (dataOut == '0);
  end

endmodule

bind pflag_async_fifo pflag_async_fifo_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W)
) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .asyncMode(asyncMode),
  .rdEnN(rdEnN), .loadN(loadN), .retransN(retransN), .dataOut(dataOut),
  .emptyN(emptyN), .fullN(fullN), .almostEmptyN(almostEmptyN),
  .almostFullN(almostFullN)
);

// File: tb/pflag_async_fifo_tb_top.sv
module pflag_async_fifo_tb_top;

  localparam int WIDTH  = 18;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic             wrClk = 1'b0;
  logic             rdClk = 1'b0;
  logic             rstN = 1'b0;
  logic             asyncMode = 1'b0;
  logic             wrEnN = 1'b1;
  logic             rdEnN = 1'b1;
  logic             loadN = 1'b1;
  logic             retransN = 1'b1;
  logic [WIDTH-1:0] dataIn = '0;
  logic [WIDTH-1:0] dataOut;
  logic             emptyN, fullN, halfFullN, almostEmptyN, almostFullN;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 wrClk = ~wrClk;
  initial begin
    #3;
    forever #5 rdClk = ~rdClk;
  end

  pflag_async_fifo #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .asyncMode(asyncMode),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .loadN(loadN), .retransN(retransN),
    .dataIn(dataIn), .dataOut(dataOut), .emptyN(emptyN), .fullN(fullN),
    .halfFullN(halfFullN), .almostEmptyN(almostEmptyN),
    .almostFullN(almostFullN)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] pat(input int n, input int i);
    return WIDTH'((i * 131 + n * 7 + 5) & 32'h3ffff);
  endfunction

  task automatic resetDut(input logic mode);
    asyncMode = mode;
    rstN = 1'b0; wrEnN = 1'b1; rdEnN = 1'b1; loadN = 1'b1; retransN = 1'b1;
    repeat (3) @(negedge wrClk);
    rstN = 1'b1;
    repeat (2) @(negedge wrClk);
  endtask

  task automatic settle();
    repeat (6) @(negedge wrClk);
  endtask

  task automatic pushWord(input logic [WIDTH-1:0] v);
    @(negedge wrClk); wrEnN = 1'b0; dataIn = v;
    @(negedge wrClk); wrEnN = 1'b1;
  endtask

  task automatic popWord(output logic [WIDTH-1:0] v);
    @(negedge rdClk); rdEnN = 1'b0;
    @(negedge rdClk); rdEnN = 1'b1; v = dataOut;
  endtask

  task automatic loadWrite(input logic [WIDTH-1:0] v);
    @(negedge wrClk); loadN = 1'b0; wrEnN = 1'b0; dataIn = v;
    @(negedge wrClk); wrEnN = 1'b1; loadN = 1'b1;
  endtask

  task automatic loadRead(output logic [WIDTH-1:0] v);
    @(negedge rdClk); loadN = 1'b0; rdEnN = 1'b0;
    @(negedge rdClk); rdEnN = 1'b1; loadN = 1'b1; v = dataOut;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] v;
    logic [WIDTH-1:0] last;

    // R11: reset state and default thresholds
    resetDut(1'b0);
    chk("R11", "emptyN", int'(emptyN), 0);
    chk("R11", "fullN", int'(fullN), 1);
    chk("R11", "halfFullN", int'(halfFullN), 1);
    chk("R11", "almostEmptyN", int'(almostEmptyN), 0);
    chk("R11", "almostFullN", int'(almostFullN), 1);
    chk("R11", "dataOut", int'(dataOut), 0);
    loadRead(v); chk("R11", "default empty threshold", int'(v), 7);
    loadRead(v); chk("R11", "default full threshold", int'(v), 7);
    popWord(v);  chk("R3", "empty read holds output", int'(v), 7);

    // R8/R9: alternation order, truncation, buffer untouched
    loadWrite(18'h3ffe5);
    loadWrite(9);
    loadRead(v); chk("R8", "empty threshold truncated", int'(v), 5);
    loadRead(v); chk("R9", "full threshold second", int'(v), 9);
    loadRead(v); chk("R9", "alternation wraps", int'(v), 5);
    settle();
    chk("R8", "load writes leave buffer empty", int'(emptyN), 0);
    chk("R9", "load reads leave buffer full flag", int'(fullN), 1);

    // R1-R6: sweep all fill levels in both modes, thresholds 3 / 2
    for (int mode = 0; mode < 2; mode++) begin
      for (int n = 0; n <= DEPTH; n++) begin
        string req;
        int writes;
        req = (mode == 1) ? "R7" : "R5";
        resetDut(mode[0]);
        loadWrite(3);
        loadWrite(2);
        writes = (n == DEPTH) ? DEPTH + 2 : n;
        for (int i = 0; i < writes; i++) pushWord(pat(n, i));
        settle();
        chk("R2", "fullN", int'(fullN), (n == DEPTH) ? 0 : 1);
        chk("R3", "emptyN", int'(emptyN), (n == 0) ? 0 : 1);
        chk("R4", "halfFullN", int'(halfFullN), (n > DEPTH / 2) ? 0 : 1);
        chk(req, "almostEmptyN", int'(almostEmptyN), (n <= 3) ? 0 : 1);
        chk((mode == 1) ? "R7" : "R6", "almostFullN", int'(almostFullN),
            (DEPTH - n <= 2) ? 0 : 1);
        last = '0;
        for (int i = 0; i < n; i++) begin
          popWord(v);
          chk("R1", "read order", int'(v), int'(pat(n, i)));
          last = pat(n, i);
        end
        popWord(v);
        chk("R3", "read past empty", int'(v), int'(last));
        chk("R3", "emptyN after drain", int'(emptyN), 0);
      end
    end

    // R7: combinational almost-empty reacts before any read-clock edge
    resetDut(1'b1);
    loadWrite(0);
    loadWrite(7);
    settle();
    chk("R7", "async almostEmptyN at zero", int'(almostEmptyN), 0);
    @(negedge wrClk); wrEnN = 1'b0; dataIn = 18'h1;
    @(posedge wrClk); #1;
    chk("R7", "async flag follows write at once", int'(almostEmptyN), 1);
    @(negedge wrClk); wrEnN = 1'b1;

    resetDut(1'b0);
    loadWrite(0);
    loadWrite(7);
    settle();
    @(negedge wrClk); wrEnN = 1'b0; dataIn = 18'h1;
    @(posedge wrClk); #1;
    chk("R7", "registered flag waits for sync", int'(almostEmptyN), 0);
    @(negedge wrClk); wrEnN = 1'b1;
    settle();
    chk("R7", "registered flag after sync", int'(almostEmptyN), 1);

    // R10: retransmit replays the frame from the first location
    resetDut(1'b0);
    for (int i = 0; i < 5; i++) pushWord(pat(99, i));
    settle();
    for (int i = 0; i < 5; i++) begin
      popWord(v); chk("R1", "first pass", int'(v), int'(pat(99, i)));
    end
    settle();
    @(negedge rdClk); retransN = 1'b0;
    @(negedge rdClk); retransN = 1'b1;
    settle();
    chk("R10", "emptyN after retransmit", int'(emptyN), 1);
    for (int i = 0; i < 5; i++) begin
      popWord(v); chk("R10", "replayed word", int'(v), int'(pat(99, i)));
    end
    chk("R10", "emptyN after replay", int'(emptyN), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule